// File: doc/BRIEF.md
# Serial Command Register Interface

This block is the serial control front end of a low-power transmitter. A host shifts commands in over a four-wire style serial link (clock, active-low select, data in) and the block decodes each complete command by its leading opcode bits and writes the matching configuration register. The registers cover band and deviation configuration, power management, carrier frequency, data rate, output power, battery threshold, sleep tail, button handling and wake-up timing. All of them take fixed default values at reset and again on a software reset command.

The serial pins are sampled through synchronisers in the system clock domain, so the serial clock must be several times slower than the system clock. The active-low interrupt pin serves two purposes. Outside a status read it is low while any event is pending. During a status read it carries the pending event bits one per serial clock, and a completed status read acknowledges the events it reported. Two small derived outputs are also provided: the modulation sign for the FSK data pin and the wake-up period in milliseconds.

Top module: `serial_cmd_if`

## Requirements
- R1: Data is sampled on each rising serial clock while select is low, most significant bit first. A high select clears the bit counter and the shifter, so a partial transfer leaves no trace in the next one.
- R2: After reset the register images are configuration 8080h, power management C000h, frequency A7D0h, data rate C800h, output power B0h (8 bits), battery threshold C200h, sleep C400h, buttons CA00h and wake-up E000h.
- R3: A command is committed only when select rises after exactly its own length: 8 bits for the output power command and 16 bits for every other command. Any other bit count changes nothing.
- R4: An 8-bit word whose top four bits are 1011 is stored whole as the output power image (on-off keying enable at bit 3, power step in bits 2..0).
- R5: A 16-bit word with top nibble 1010 updates the frequency image only when its low 12 bits lie in 96..3903. Otherwise the previous image is kept.
- R6: 16-bit words are decoded most specific first. FF00h and CC00h are exact codes. The upper bytes C0h, C2h, C4h, C8h and CAh select power management, battery threshold, sleep, data rate and buttons. Top nibble 1010 selects frequency, top bits 100 select configuration and top bits 111 select wake-up. Each write stores the whole word. Any other code changes nothing.
- R7: While a status read is in progress (first byte CCh), bit k of the event snapshot drives the interrupt pin while the bit count is 8+k, with 1 meaning pending. Index 0 is reset, 1 to 4 are buttons 1 to 4, 5 is low battery and 6 is wake-up. Later bits read 0.
- R8: Event pulses set pending flags. Outside a status read, the interrupt pin is low when any flag is set. Only a completed 16-bit CC00h read clears the flags it reported; an aborted read clears nothing.
- R9: The word FF00h restores every register default and sets the reset event flag, the same as power-up.
- R10: The wake-up period output is m shifted left by r, where m is bits 7..0 and r is bits 12..8 of the wake-up image. An r above 23 counts as 23.
- R11: The modulation sign output is the polarity bit (bit 3 of the configuration image) XOR the FSK data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| sel_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data in |
| fsk_in | input | 1 | FSK data pin |
| evt_btn | input | 4 | Button event pulses, button 1 at bit 0 |
| evt_lbd | input | 1 | Low battery event pulse |
| evt_wk | input | 1 | Wake-up timer event pulse |
| irq_n | output | 1 | Interrupt / serial status output |
| fsk_sign | output | 1 | Modulation sign |
| cfg_word | output | 16 | Configuration image |
| pmgmt_word | output | 16 | Power management image |
| freq_word | output | 16 | Frequency image |
| rate_word | output | 16 | Data rate image |
| pa_word | output | 8 | Output power image |
| lbat_word | output | 16 | Battery threshold image |
| sleep_word | output | 16 | Sleep image |
| pbtn_word | output | 16 | Button image |
| wkup_word | output | 16 | Wake-up image |
| wk_period_ms | output | 31 | Wake-up period in ms |

## Verification
The assertions assume that the serial pins change only between sampling points, with each serial clock phase lasting longer than the synchroniser delay, and that event inputs are single-cycle pulses. The stimulus drives every serial pin on the falling system clock and holds each serial clock phase for eight system cycles. Under these assumptions each rising serial clock is seen exactly once, and the register images change only in the cycle after a commit. The frequency image therefore never leaves its legal range, even when illegal values are sent.

// File: rtl/sci_pkg.sv
package sci_pkg;
   localparam logic [15:0] DEF_CFG  = 16'h8080;
   localparam logic [15:0] DEF_PMG  = 16'hC000;
   localparam logic [15:0] DEF_FRQ  = 16'hA7D0;
   localparam logic [15:0] DEF_RATE = 16'hC800;
   localparam logic [15:0] DEF_LBAT = 16'hC200;
   localparam logic [15:0] DEF_SLP  = 16'hC400;
   localparam logic [15:0] DEF_PBT  = 16'hCA00;
   localparam logic [15:0] DEF_WKUP = 16'hE000;
   localparam logic [7:0]  DEF_PA   = 8'hB0;
   localparam logic [11:0] FRQ_MIN  = 12'd96;
   localparam logic [11:0] FRQ_MAX  = 12'd3903;
   localparam logic [7:0]  STAT_HDR = 8'hCC;

   typedef enum logic [3:0] {
      K_NONE, K_SRST, K_STAT, K_PMG, K_LBAT, K_SLP, K_RATE,
      K_PBT, K_FRQ, K_PA, K_CFG, K_WKUP
   } cmd_kind_t;
endpackage

// File: rtl/sci_frontend.sv
module sci_frontend #(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 5,
   parameter int WORD_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              sel_n,
   input  logic              sdi,
   output logic [WORD_W-1:0] shreg,
   output logic [CNT_W-1:0]  bitcnt,
   output logic              sel_rise,
   output logic              sel_act
);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic [2:0] raw, syn;
   assign raw = {sck, sel_n, sdi};

   generate
      if (SYNC_STAGES == 0) begin : g_bypass
         assign syn = raw;
      end else begin : g_sync
         logic [2:0] stg [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= 3'b010;
            end else begin
               stg[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign syn = stg[SYNC_STAGES-1];
      end
   endgenerate

   logic sck_s, sel_s, sdi_s, sck_d, sel_d;
   assign sck_s = syn[2];
   assign sel_s = syn[1];
   assign sdi_s = syn[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d  <= 1'b0;
         sel_d  <= 1'b1;
         shreg  <= '0;
         bitcnt <= '0;
      end else begin
         sck_d <= sck_s;
         sel_d <= sel_s;
         if (sel_s) begin
            shreg  <= '0;
            bitcnt <= '0;
         end else if (sck_s && !sck_d) begin
            shreg <= {shreg[WORD_W-2:0], sdi_s};
            if (bitcnt != CNT_TOP) bitcnt <= bitcnt + 1'b1;
         end
      end
   end

   assign sel_rise = sel_s && !sel_d;
   assign sel_act  = !sel_s;
endmodule

// File: rtl/sci_decode.sv
module sci_decode
   import sci_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic [15:0]      shreg,
   input  logic [CNT_W-1:0] bitcnt,
   output cmd_kind_t        kind
);
   always_comb begin
      kind = K_NONE;
      if (bitcnt == CNT_W'(8)) begin
         if (shreg[7:4] == 4'b1011) kind = K_PA;
      end else if (bitcnt == CNT_W'(16)) begin
         if      (shreg == 16'hFF00)          kind = K_SRST;
         else if (shreg == 16'hCC00)          kind = K_STAT;
         else if (shreg[15:8] == 8'hC0)       kind = K_PMG;
         else if (shreg[15:8] == 8'hC2)       kind = K_LBAT;
         else if (shreg[15:8] == 8'hC4)       kind = K_SLP;
         else if (shreg[15:8] == 8'hC8)       kind = K_RATE;
         else if (shreg[15:8] == 8'hCA)       kind = K_PBT;
         else if (shreg[15:12] == 4'b1010)    kind = K_FRQ;
         else if (shreg[15:13] == 3'b100)     kind = K_CFG;
         else if (shreg[15:13] == 3'b111)     kind = K_WKUP;
      end
   end
endmodule

// File: rtl/sci_regs.sv
module sci_regs
   import sci_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  cmd_kind_t   kind,
   input  logic [15:0] data,
   output logic [15:0] cfg_word,
   output logic [15:0] pmgmt_word,
   output logic [15:0] freq_word,
   output logic [15:0] rate_word,
   output logic [7:0]  pa_word,
   output logic [15:0] lbat_word,
   output logic [15:0] sleep_word,
   output logic [15:0] pbtn_word,
   output logic [15:0] wkup_word
);
   logic freq_ok;
   assign freq_ok = (data[11:0] >= FRQ_MIN) && (data[11:0] <= FRQ_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_word <= DEF_CFG;  pmgmt_word <= DEF_PMG; freq_word  <= DEF_FRQ;
         rate_word <= DEF_RATE; pa_word  <= DEF_PA;  lbat_word  <= DEF_LBAT;
         sleep_word <= DEF_SLP; pbtn_word <= DEF_PBT; wkup_word <= DEF_WKUP;
      end else if (wr) begin
         case (kind)
            K_SRST: begin
               cfg_word <= DEF_CFG;  pmgmt_word <= DEF_PMG; freq_word  <= DEF_FRQ;
               rate_word <= DEF_RATE; pa_word  <= DEF_PA;  lbat_word  <= DEF_LBAT;
               sleep_word <= DEF_SLP; pbtn_word <= DEF_PBT; wkup_word <= DEF_WKUP;
            end
            K_CFG:  cfg_word   <= data;
            K_PMG:  pmgmt_word <= data;
            K_FRQ:  if (freq_ok) freq_word <= data;
            K_RATE: rate_word  <= data;
            K_PA:   pa_word    <= data[7:0];
            K_LBAT: lbat_word  <= data;
            K_SLP:  sleep_word <= data;
            K_PBT:  pbtn_word  <= data;
            K_WKUP: wkup_word  <= data;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/sci_status.sv
module sci_status
   import sci_pkg::*;
#(
   parameter int NUM_BTN = 4,
   parameter int CNT_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_BTN-1:0] evt_btn,
   input  logic               evt_lbd,
   input  logic               evt_wk,
   input  logic               ack,
   input  logic               srst,
   input  logic               sel_act,
   input  logic [CNT_W-1:0]   bitcnt,
   input  logic [7:0]         hdr_byte,
   output logic               irq_n
);
   localparam int NST = NUM_BTN + 3;

   logic [NST-1:0] flags, snap, evt_vec;
   logic           rd_active, sbit;
   logic [CNT_W-1:0] idx;

   assign evt_vec = {evt_wk, evt_lbd, evt_btn, 1'b0};
   assign idx     = bitcnt - CNT_W'(8);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags     <= NST'(1);
         snap      <= '0;
         rd_active <= 1'b0;
      end else begin
         if (!sel_act) rd_active <= 1'b0;
         else if (!rd_active && bitcnt == CNT_W'(8) && hdr_byte == STAT_HDR) begin
            rd_active <= 1'b1;
            snap      <= flags;
         end
         if (srst)     flags <= NST'(1);
         else if (ack) flags <= (flags & ~snap) | evt_vec;
         else          flags <= flags | evt_vec;
      end
   end

   always_comb begin
      sbit = 1'b0;
      for (int i = 0; i < NST; i++)
         if (idx == CNT_W'(i)) sbit = snap[i];
   end

   assign irq_n = rd_active ? sbit : ~(|flags);
endmodule

// File: rtl/serial_cmd_if.sv
module serial_cmd_if
   import sci_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 5,
   parameter int WORD_W      = 16,
   parameter int NUM_BTN     = 4,
   parameter int EXP_MAX     = 23,
   parameter int PER_W       = 8 + EXP_MAX
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck,
   input  logic               sel_n,
   input  logic               sdi,
   input  logic               fsk_in,
   input  logic [NUM_BTN-1:0] evt_btn,
   input  logic               evt_lbd,
   input  logic               evt_wk,
   output logic               irq_n,
   output logic               fsk_sign,
   output logic [15:0]        cfg_word,
   output logic [15:0]        pmgmt_word,
   output logic [15:0]        freq_word,
   output logic [15:0]        rate_word,
   output logic [7:0]         pa_word,
   output logic [15:0]        lbat_word,
   output logic [15:0]        sleep_word,
   output logic [15:0]        pbtn_word,
   output logic [15:0]        wkup_word,
   output logic [PER_W-1:0]   wk_period_ms
);
   generate
      if (WORD_W != 16) begin : g_bad_word
         $error("serial_cmd_if: WORD_W must be 16");
      end
      if (CNT_W < 5) begin : g_bad_cnt
         $error("serial_cmd_if: CNT_W must count past 16");
      end
      if (EXP_MAX < 0 || EXP_MAX > 31) begin : g_bad_exp
         $error("serial_cmd_if: EXP_MAX out of 5-bit range");
      end
   endgenerate

   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  bitcnt;
   logic              commit, sel_act;
   cmd_kind_t         kind;

   sci_frontend #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W), .WORD_W(WORD_W)) u_front (
      .clk(clk), .rst_n(rst_n), .sck(sck), .sel_n(sel_n), .sdi(sdi),
      .shreg(shreg), .bitcnt(bitcnt), .sel_rise(commit), .sel_act(sel_act));

   sci_decode #(.CNT_W(CNT_W)) u_dec (.shreg(shreg), .bitcnt(bitcnt), .kind(kind));

   sci_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr(commit), .kind(kind), .data(shreg),
      .cfg_word(cfg_word), .pmgmt_word(pmgmt_word), .freq_word(freq_word),
      .rate_word(rate_word), .pa_word(pa_word), .lbat_word(lbat_word),
      .sleep_word(sleep_word), .pbtn_word(pbtn_word), .wkup_word(wkup_word));

   sci_status #(.NUM_BTN(NUM_BTN), .CNT_W(CNT_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .evt_btn(evt_btn), .evt_lbd(evt_lbd), .evt_wk(evt_wk),
      .ack(commit && kind == K_STAT), .srst(commit && kind == K_SRST),
      .sel_act(sel_act), .bitcnt(bitcnt), .hdr_byte(shreg[7:0]), .irq_n(irq_n));

   logic [4:0] wk_exp, wk_exp_c;
   assign wk_exp       = wkup_word[12:8];
   assign wk_exp_c     = (wk_exp > 5'(EXP_MAX)) ? 5'(EXP_MAX) : wk_exp;
   assign wk_period_ms = PER_W'(wkup_word[7:0]) << wk_exp_c;
   assign fsk_sign     = cfg_word[3] ^ fsk_in;
endmodule

// File: rtl/serial_cmd_if_chk.sv
module serial_cmd_if_chk #(
   parameter int CNT_W = 5,
   parameter int PER_W = 31
) (
   input logic             clk,
   input logic             rst_n,
   input logic             commit,
   input logic             sel_act,
   input logic [CNT_W-1:0] bitcnt,
   input logic [15:0]      cfg_word,
   input logic [15:0]      freq_word,
   input logic [15:0]      wkup_word,
   input logic [7:0]       pa_word,
   input logic [PER_W-1:0] wk_period_ms
);
   a_r1_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_act |=> bitcnt == '0);

   a_r3_no_commit_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(cfg_word) && $stable(freq_word) && $stable(wkup_word) && $stable(pa_word));

   a_r4_pa_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      pa_word[7:4] == 4'b1011);

   a_r5_freq_window: assert property (@(posedge clk) disable iff (!rst_n)
      freq_word[11:0] >= 12'd96 && freq_word[11:0] <= 12'd3903);

   a_r10_period_bits: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wk_period_ms) <= 8);
endmodule

bind serial_cmd_if serial_cmd_if_chk #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .commit(commit), .sel_act(sel_act), .bitcnt(bitcnt),
   .cfg_word(cfg_word), .freq_word(freq_word), .wkup_word(wkup_word),
   .pa_word(pa_word), .wk_period_ms(wk_period_ms));

// File: tb/serial_cmd_if_test.sv
module serial_cmd_if_test;
   localparam int HALF = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, sel_n = 1'b1, sdi = 1'b0, fsk_in = 1'b0;
   logic [3:0] evt_btn = '0;
   logic evt_lbd = 1'b0, evt_wk = 1'b0;
   logic irq_n, fsk_sign;
   logic [15:0] cfg_word, pmgmt_word, freq_word, rate_word, lbat_word, sleep_word, pbtn_word, wkup_word;
   logic [7:0] pa_word;
   logic [30:0] wk_period_ms;

   always #4 clk = ~clk;

   serial_cmd_if uut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .sel_n(sel_n), .sdi(sdi), .fsk_in(fsk_in),
      .evt_btn(evt_btn), .evt_lbd(evt_lbd), .evt_wk(evt_wk), .irq_n(irq_n), .fsk_sign(fsk_sign),
      .cfg_word(cfg_word), .pmgmt_word(pmgmt_word), .freq_word(freq_word), .rate_word(rate_word),
      .pa_word(pa_word), .lbat_word(lbat_word), .sleep_word(sleep_word), .pbtn_word(pbtn_word),
      .wkup_word(wkup_word), .wk_period_ms(wk_period_ms));

   int checks = 0, errors = 0;
   bit done = 0;

   int          q_sel[$];
   logic [30:0] q_val[$];
   string       q_tag[$];

   logic [15:0] e_cfg, e_pmg, e_frq, e_rate, e_lbat, e_slp, e_pbt, e_wk;
   logic [7:0]  e_pa;

   function automatic logic [30:0] get_out(int s);
      case (s)
         0: return 31'(cfg_word);   1: return 31'(pmgmt_word);
         2: return 31'(freq_word);  3: return 31'(rate_word);
         4: return 31'(pa_word);    5: return 31'(lbat_word);
         6: return 31'(sleep_word); 7: return 31'(pbtn_word);
         8: return 31'(wkup_word);  9: return wk_period_ms;
         10: return 31'(irq_n);
         default: return 31'(fsk_sign);
      endcase
   endfunction

   task automatic check(string tag, logic [30:0] act, logic [30:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic expect_out(int s, logic [30:0] v, string tag);
      q_sel.push_back(s); q_val.push_back(v); q_tag.push_back(tag);
   endtask

   task automatic monitor_drain();
      @(negedge clk);
      while (q_sel.size() > 0) begin
         int s = q_sel.pop_front();
         logic [30:0] v = q_val.pop_front();
         string t = q_tag.pop_front();
         check(t, get_out(s), v);
      end
   endtask

   function automatic logic [30:0] period_of(logic [15:0] w);
      int r = int'(w[12:8]);
      if (r > 23) r = 23;
      return 31'(w[7:0]) << r;
   endfunction

   task automatic expect_all(string tag);
      expect_out(0, 31'(e_cfg), tag);  expect_out(1, 31'(e_pmg), tag);
      expect_out(2, 31'(e_frq), tag);  expect_out(3, 31'(e_rate), tag);
      expect_out(4, 31'(e_pa), tag);   expect_out(5, 31'(e_lbat), tag);
      expect_out(6, 31'(e_slp), tag);  expect_out(7, 31'(e_pbt), tag);
      expect_out(8, 31'(e_wk), tag);   expect_out(9, period_of(e_wk), tag);
   endtask

   task automatic model_defaults();
      e_cfg = 16'h8080; e_pmg = 16'hC000; e_frq = 16'hA7D0; e_rate = 16'hC800;
      e_pa = 8'hB0; e_lbat = 16'hC200; e_slp = 16'hC400; e_pbt = 16'hCA00; e_wk = 16'hE000;
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   // Shift n bits of w, MSB first; optionally compare status bits on irq_n.
   task automatic xfer(logic [31:0] w, int n, bit chk_stat, logic [6:0] exp_stat, string tag);
      sel_n = 1'b0;
      wait_clk(HALF);
      for (int i = n - 1; i >= 0; i--) begin
         int pos = n - 1 - i;
         sdi = w[i];
         wait_clk(HALF);
         if (chk_stat && pos >= 8) begin
            logic exp_b = (pos - 8 < 7) ? exp_stat[pos-8] : 1'b0;
            check(tag, 31'(irq_n), 31'(exp_b));
         end
         sck = 1'b1;
         wait_clk(HALF);
         sck = 1'b0;
      end
      wait_clk(HALF);
      sel_n = 1'b1;
      wait_clk(12);
   endtask

   task automatic send(logic [31:0] w, int n);
      xfer(w, n, 1'b0, 7'd0, "");
   endtask

   task automatic pulse(int which);
      case (which)
         0: evt_btn[1] = 1'b1;
         1: evt_wk = 1'b1;
         default: evt_lbd = 1'b1;
      endcase
      wait_clk(1);
      evt_btn = '0; evt_wk = 1'b0; evt_lbd = 1'b0;
      wait_clk(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_defaults();
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);
      // R2: defaults, reset event pending
      expect_all("R2 reset defaults");
      expect_out(10, 31'(0), "R2 reset event pending");
      monitor_drain();

      // R7: status read reports reset event only; R8 ack clears it
      xfer(32'hCC00, 16, 1'b1, 7'b0000001, "R7 status bits after reset");
      check("R8 irq released after ack", 31'(irq_n), 31'(1));

      // R6/R1: configuration, MSB first
      send(32'h9A5F, 16); e_cfg = 16'h9A5F;
      expect_all("R6 R1 configuration write"); monitor_drain();
      // R11
      fsk_in = 1'b0; wait_clk(1); check("R11 sign with fsk low", 31'(fsk_sign), 31'(1));
      fsk_in = 1'b1; wait_clk(1); check("R11 sign with fsk high", 31'(fsk_sign), 31'(0));
      send(32'h8000, 16); e_cfg = 16'h8000;
      wait_clk(1); check("R11 sign polarity clear", 31'(fsk_sign), 31'(1));
      fsk_in = 1'b0;

      // R4: 8-bit power command
      send(32'hBD, 8); e_pa = 8'hBD;
      expect_all("R4 power byte"); monitor_drain();
      // R3: power code sent as 16 bits ignored
      send(32'hB3A0, 16);
      expect_all("R3 power as 16 bits ignored"); monitor_drain();

      // R5: frequency range
      send(32'hA060, 16); e_frq = 16'hA060;
      expect_all("R5 freq lower bound"); monitor_drain();
      send(32'hAF3F, 16); e_frq = 16'hAF3F;
      expect_all("R5 freq upper bound"); monitor_drain();
      send(32'hA05F, 16);
      expect_all("R5 freq below range kept"); monitor_drain();
      send(32'hAF40, 16);
      expect_all("R5 freq above range kept"); monitor_drain();

      // R6: the 8-bit-prefix registers
      send(32'hC03A, 16); e_pmg = 16'hC03A;
      send(32'hC215, 16); e_lbat = 16'hC215;
      send(32'hC47E, 16); e_slp = 16'hC47E;
      send(32'hC823, 16); e_rate = 16'hC823;
      send(32'hCA55, 16); e_pbt = 16'hCA55;
      expect_all("R6 byte-prefixed registers"); monitor_drain();
      send(32'hC100, 16);
      expect_all("R6 unknown code ignored"); monitor_drain();

      // R10: wake-up period
      send(32'hE5A3, 16); e_wk = 16'hE5A3;
      expect_all("R10 wake period r=5"); monitor_drain();
      check("R10 period value", wk_period_ms, 31'd5216);
      send(32'hF7FF, 16); e_wk = 16'hF7FF;
      expect_all("R10 wake period r=23"); monitor_drain();
      send(32'hFFC1, 16); e_wk = 16'hFFC1;
      expect_all("R10 wake period r=31 clamped"); monitor_drain();

      // R3: wrong lengths
      send(32'hA100, 12);
      send(32'hA10000, 24);
      send(32'hB, 4);
      expect_all("R3 wrong length ignored"); monitor_drain();

      // R1: partial transfer then select high clears shifter
      send(32'h5, 4);
      send(32'hB2, 8); e_pa = 8'hB2;
      expect_all("R1 shifter cleared by select"); monitor_drain();

      // R8/R7: events and status read
      pulse(0); pulse(1);
      check("R8 irq on events", 31'(irq_n), 31'(0));
      xfer(32'hCC00, 16, 1'b1, 7'b1000100, "R7 status order button2 wake");
      check("R8 ack releases irq", 31'(irq_n), 31'(1));

      // R8: aborted read does not acknowledge
      pulse(2);
      xfer(32'hCC0, 12, 1'b1, 7'b0100000, "R7 partial read bits");
      check("R8 aborted read keeps flag", 31'(irq_n), 31'(0));
      xfer(32'hCC00, 16, 1'b1, 7'b0100000, "R7 low battery bit");
      check("R8 full read clears flag", 31'(irq_n), 31'(1));

      // R9: software reset
      send(32'hFF00, 16); model_defaults();
      expect_all("R9 software reset defaults");
      expect_out(10, 31'(0), "R9 reset event raised");
      monitor_drain();

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule